// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks the fetch state of every hardware thread in a multithreaded front end. For each thread it holds a status code and four sticky stall flags, one for each downstream stage (decode, rename, execute, commit). Each cycle it takes block and unblock pulses, squash requests from commit and from decode, a flag saying the reorder buffer is still squashing, a global context-switch stall, and cache events from the fetch engine. From these it computes the next status of every thread through a fixed priority chain.

A thread that is redirected gets a one-cycle redirect pulse carrying the new PC. If it had a cache request outstanding or waiting for retry, it also gets a cancel pulse. The block reports a per-thread "status changed" pulse for transitions made by the priority chain. It also keeps an aggregate stage-active level with activate and deactivate pulses that fire only on edges of that level.

All interfaces are plain control and status pins sampled every cycle; there is no data stream and so no valid/ready handshake or back-pressure. Every output is registered and reflects the inputs of the previous cycle.

Top module: `fetch_status_ctrl`

## Requirements
- R1: Stall flag bit `t*4+s` (s: 0 decode, 1 rename, 2 execute, 3 commit) is set by `stall_set` and cleared by `stall_clr`; when both arrive together the clear wins; `stall_flags` shows the result one cycle later.
- R2: `flag_err[t]` pulses one cycle after any stage of thread t receives a clear while its flag is clear, or a clear together with a set.
- R3: A commit squash has top priority: next status Squashing (code 1), `status_chg` and `redir_valid` pulse, `redir_pc` takes the commit PC, and `cancel_fetch` pulses if the thread was in WaitResponse (3) or WaitRetry (4).
- R4: Without a commit squash, `rob_busy` forces status Squashing with `status_chg` set and no redirect.
- R5: A decode squash acts like R3 with the decode PC, but only if the thread is not already Squashing; otherwise it is ignored and evaluation continues with R6.
- R6: A thread is stalled if `ctx_switch` is high or any of its updated flags is set; a stalled thread not in codes 3 or 4 goes to Blocked (code 2) with `status_chg`.
- R7: A stall never overrides codes 3 or 4; a cache response (event 3) in WaitResponse goes to Blocked if stalled, else to AccessDone (code 5), without `status_chg`.
- R8: When none of R3 to R6 applies, a thread in Blocked or Squashing returns to Running (code 0) with `status_chg`.
- R9: Otherwise `status_chg` stays low and cache events (`cache_evt` 2 bits per thread: 0 none, 1 issue, 2 nack, 3 response) move Running to WaitResponse (issue) or WaitRetry (nack), WaitRetry to WaitResponse (issue), and AccessDone to Running unconditionally.
- R10: `stage_active` is high when any thread enabled by `thr_en` has a next status of Running, Squashing or AccessDone; `stage_act` and `stage_deact` pulse only on its rising and falling edges.
- R11: After reset all flags are clear, all statuses are Running, and `stage_active` and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_en | input | NT | Threads counted for stage activity |
| ctx_switch | input | 1 | Global context-switch stall |
| stall_set | input | NT*4 | Per-thread, per-stage block pulses |
| stall_clr | input | NT*4 | Per-thread, per-stage unblock pulses |
| cmt_squash | input | NT | Squash request from commit |
| cmt_pc | input | NT*AW | Commit redirect target |
| rob_busy | input | NT | Reorder buffer still squashing |
| dec_squash | input | NT | Squash request from decode |
| dec_pc | input | NT*AW | Decode redirect target |
| cache_evt | input | NT*2 | Cache event per thread |
| status | output | NT*3 | Status code per thread |
| stall_flags | output | NT*4 | Sticky stall flags |
| flag_err | output | NT | Block/unblock protocol error pulse |
| status_chg | output | NT | Chain-driven status change pulse |
| redir_valid | output | NT | Redirect pulse |
| redir_pc | output | NT*AW | Redirect target, held between redirects |
| cancel_fetch | output | NT | Drop outstanding or retrying cache request |
| stage_active | output | 1 | Aggregate stage activity |
| stage_act | output | 1 | Activity rising-edge pulse |
| stage_deact | output | 1 | Activity falling-edge pulse |

## Verification
Every result of this block is due on the first clock edge after the inputs that cause it, because each output passes through exactly one register. This covers status codes, change, redirect, cancel and error pulses, flags, and activity pulses. The bench drives inputs on the falling edge, lets one rising edge pass, and compares all outputs on the next falling edge against a model advanced by one step. `redir_pc` is compared only in cycles where a redirect is expected, since it holds its value otherwise.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int NSTG = 4;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SQUASH = 3'd1,
    ST_BLOCK  = 3'd2,
    ST_WRESP  = 3'd3,
    ST_WRETRY = 3'd4,
    ST_ADONE  = 3'd5
  } fstat_e;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_ISSUE = 2'd1,
    EV_NACK  = 2'd2,
    EV_RESP  = 2'd3
  } cevt_e;
endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags
  import fsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTG-1:0] set_i,
  input  logic [NSTG-1:0] clr_i,
  output logic [NSTG-1:0] flags_q,
  output logic [NSTG-1:0] flags_nxt,
  output logic            err_q
);
  logic err_d;

  // clear wins over a simultaneous set
  assign flags_nxt = (flags_q | set_i) & ~clr_i;
  assign err_d     = |(clr_i & (~flags_q | set_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      err_q   <= 1'b0;
    end else begin
      flags_q <= flags_nxt;
      err_q   <= err_d;
    end
  end
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
  import fsc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stalled_i,
  input  logic          cmt_sq_i,
  input  logic [AW-1:0] cmt_pc_i,
  input  logic          rob_busy_i,
  input  logic          dec_sq_i,
  input  logic [AW-1:0] dec_pc_i,
  input  logic [1:0]    evt_i,
  output fstat_e        st_q,
  output logic          live_nxt,
  output logic          chg_q,
  output logic          redir_q,
  output logic [AW-1:0] redir_pc_q,
  output logic          cancel_q
);
  fstat_e        st_d;
  logic          chg_d, redir_d, cancel_d;
  logic [AW-1:0] pc_d;
  logic          waiting;
  cevt_e         evt;

  assign evt     = cevt_e'(evt_i);
  assign waiting = (st_q == ST_WRESP) || (st_q == ST_WRETRY);

  always_comb begin
    st_d     = st_q;
    chg_d    = 1'b0;
    redir_d  = 1'b0;
    cancel_d = 1'b0;
    pc_d     = redir_pc_q;
    if (cmt_sq_i) begin
      st_d = ST_SQUASH; chg_d = 1'b1; redir_d = 1'b1;
      pc_d = cmt_pc_i;  cancel_d = waiting;
    end else if (rob_busy_i) begin
      st_d = ST_SQUASH; chg_d = 1'b1;
    end else if (dec_sq_i && st_q != ST_SQUASH) begin
      st_d = ST_SQUASH; chg_d = 1'b1; redir_d = 1'b1;
      pc_d = dec_pc_i;  cancel_d = waiting;
    end else if (stalled_i && !waiting) begin
      st_d = ST_BLOCK;  chg_d = 1'b1;
    end else if (st_q == ST_BLOCK || st_q == ST_SQUASH) begin
      st_d = ST_RUN;    chg_d = 1'b1;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (evt == EV_ISSUE)     st_d = ST_WRESP;
          else if (evt == EV_NACK) st_d = ST_WRETRY;
        end
        ST_WRETRY: if (evt == EV_ISSUE) st_d = ST_WRESP;
        ST_WRESP:  if (evt == EV_RESP)  st_d = stalled_i ? ST_BLOCK : ST_ADONE;
        ST_ADONE:  st_d = ST_RUN;
        default:   st_d = st_q;
      endcase
    end
  end

  assign live_nxt = (st_d == ST_RUN) || (st_d == ST_SQUASH) || (st_d == ST_ADONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      chg_q      <= 1'b0;
      redir_q    <= 1'b0;
      cancel_q   <= 1'b0;
      redir_pc_q <= '0;
    end else begin
      st_q       <= st_d;
      chg_q      <= chg_d;
      redir_q    <= redir_d;
      cancel_q   <= cancel_d;
      redir_pc_q <= pc_d;
    end
  end
endmodule

// File: rtl/fsc_activity.sv
module fsc_activity #(
  parameter int NT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] live_i,
  input  logic [NT-1:0] en_i,
  output logic          active_q,
  output logic          act_q,
  output logic          deact_q
);
  logic active_d;
  assign active_d = |(live_i & en_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      act_q    <= 1'b0;
      deact_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      act_q    <= active_d & ~active_q;
      deact_q  <= ~active_d & active_q;
    end
  end
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
  import fsc_pkg::*;
#(
  parameter int NT = 2,
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NT-1:0]      thr_en,
  input  logic               ctx_switch,
  input  logic [NT*NSTG-1:0] stall_set,
  input  logic [NT*NSTG-1:0] stall_clr,
  input  logic [NT-1:0]      cmt_squash,
  input  logic [NT*AW-1:0]   cmt_pc,
  input  logic [NT-1:0]      rob_busy,
  input  logic [NT-1:0]      dec_squash,
  input  logic [NT*AW-1:0]   dec_pc,
  input  logic [NT*2-1:0]    cache_evt,
  output logic [NT*3-1:0]    status,
  output logic [NT*NSTG-1:0] stall_flags,
  output logic [NT-1:0]      flag_err,
  output logic [NT-1:0]      status_chg,
  output logic [NT-1:0]      redir_valid,
  output logic [NT*AW-1:0]   redir_pc,
  output logic [NT-1:0]      cancel_fetch,
  output logic               stage_active,
  output logic               stage_act,
  output logic               stage_deact
);
  logic [NT-1:0] live;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [NSTG-1:0] fl_nxt;
    fstat_e          st;

    fsc_stall_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (stall_set[t*NSTG +: NSTG]),
      .clr_i     (stall_clr[t*NSTG +: NSTG]),
      .flags_q   (stall_flags[t*NSTG +: NSTG]),
      .flags_nxt (fl_nxt),
      .err_q     (flag_err[t])
    );

    fsc_thread_fsm #(.AW(AW)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .stalled_i  (ctx_switch | (|fl_nxt)),
      .cmt_sq_i   (cmt_squash[t]),
      .cmt_pc_i   (cmt_pc[t*AW +: AW]),
      .rob_busy_i (rob_busy[t]),
      .dec_sq_i   (dec_squash[t]),
      .dec_pc_i   (dec_pc[t*AW +: AW]),
      .evt_i      (cache_evt[t*2 +: 2]),
      .st_q       (st),
      .live_nxt   (live[t]),
      .chg_q      (status_chg[t]),
      .redir_q    (redir_valid[t]),
      .redir_pc_q (redir_pc[t*AW +: AW]),
      .cancel_q   (cancel_fetch[t])
    );

    assign status[t*3 +: 3] = st;
  end

  fsc_activity #(.NT(NT)) u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .live_i   (live),
    .en_i     (thr_en),
    .active_q (stage_active),
    .act_q    (stage_act),
    .deact_q  (stage_deact)
  );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int NT = 2,
  parameter int AW = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NT*4-1:0]    stall_set,
  input logic [NT-1:0]      cmt_squash,
  input logic [NT-1:0]      rob_busy,
  input logic [NT-1:0]      dec_squash,
  input logic [NT*2-1:0]    cache_evt,
  input logic [NT*3-1:0]    status,
  input logic [NT*4-1:0]    stall_flags,
  input logic [NT-1:0]      redir_valid,
  input logic [NT-1:0]      cancel_fetch,
  input logic               stage_act,
  input logic               stage_deact
);
  // R1: a flag only rises after its set pulse
  a_r1_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_flags & ~$past(stall_flags) & ~$past(stall_set)) == '0);

  // R10: activate and deactivate never together
  a_r10_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stage_act, stage_deact}));

  for (genvar t = 0; t < NT; t++) begin : g_chk
    // R3: commit squash lands in Squashing with a redirect
    a_r3_cmt_squash: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_squash[t] |=> (status[t*3 +: 3] == 3'd1) && redir_valid[t]);

    // R5: decode squash ignored while already Squashing
    a_r5_dec_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_squash[t] && !cmt_squash[t] && !rob_busy[t] && status[t*3 +: 3] == 3'd1)
      |=> !redir_valid[t]);

    // R7: a pending response wait survives anything but squashes and the response
    a_r7_wait_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmt_squash[t] && !rob_busy[t] && !dec_squash[t] &&
       status[t*3 +: 3] == 3'd3 && cache_evt[t*2 +: 2] != 2'd3)
      |=> status[t*3 +: 3] == 3'd3);

    // R3: cancel only when a redirect happens
    a_r3_cancel_redir: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_fetch[t] |-> redir_valid[t]);
  end
endmodule

bind fetch_status_ctrl fsc_checker #(.NT(NT), .AW(AW)) u_fsc_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall_set    (stall_set),
  .cmt_squash   (cmt_squash),
  .rob_busy     (rob_busy),
  .dec_squash   (dec_squash),
  .cache_evt    (cache_evt),
  .status       (status),
  .stall_flags  (stall_flags),
  .redir_valid  (redir_valid),
  .cancel_fetch (cancel_fetch),
  .stage_act    (stage_act),
  .stage_deact  (stage_deact)
);

// File: tb/fetch_status_ctrl_tb.sv
module fetch_status_ctrl_tb;
  localparam int NT = 2;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NT-1:0]    thr_en;
  logic             ctx;
  logic [NT*4-1:0]  sset, sclr;
  logic [NT-1:0]    csq, rob, dsq;
  logic [NT*AW-1:0] cpc, dpc;
  logic [NT*2-1:0]  evt;

  logic [NT*3-1:0]  status;
  logic [NT*4-1:0]  flags;
  logic [NT-1:0]    ferr, chg, rv, cancel;
  logic [NT*AW-1:0] rpc;
  logic             act_lvl, act_p, deact_p;

  fetch_status_ctrl #(.NT(NT), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_en(thr_en), .ctx_switch(ctx),
    .stall_set(sset), .stall_clr(sclr), .cmt_squash(csq), .cmt_pc(cpc),
    .rob_busy(rob), .dec_squash(dsq), .dec_pc(dpc), .cache_evt(evt),
    .status(status), .stall_flags(flags), .flag_err(ferr), .status_chg(chg),
    .redir_valid(rv), .redir_pc(rpc), .cancel_fetch(cancel),
    .stage_active(act_lvl), .stage_act(act_p), .stage_deact(deact_p)
  );

  int checks = 0;
  int errors = 0;

  // model state
  int         m_st  [NT];
  logic [3:0] m_fl  [NT];
  logic [AW-1:0] m_pc [NT];
  logic       m_act;
  // expected outputs after the edge
  int         e_st  [NT];
  logic [3:0] e_fl  [NT];
  logic       e_err [NT], e_chg [NT], e_rv [NT], e_can [NT];
  logic       e_act, e_actp, e_deactp;
  string      e_tag [NT];

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rule_next(int t, logic stl, output logic c, output logic r,
                                   output logic cn, output string tag);
    int  st = m_st[t];
    logic waitg = (st == 3) || (st == 4);
    int  ns = st;
    c = 0; r = 0; cn = 0; tag = "R9";
    if (csq[t]) begin ns = 1; c = 1; r = 1; cn = waitg; tag = "R3"; end
    else if (rob[t]) begin ns = 1; c = 1; tag = "R4"; end
    else if (dsq[t] && st != 1) begin ns = 1; c = 1; r = 1; cn = waitg; tag = "R5"; end
    else if (stl && !waitg) begin ns = 2; c = 1; tag = "R6"; end
    else if (st == 1 || st == 2) begin ns = 0; c = 1; tag = "R8"; end
    else begin
      case (st)
        0: if (evt[t*2 +: 2] == 2'd1) ns = 3; else if (evt[t*2 +: 2] == 2'd2) ns = 4;
        4: if (evt[t*2 +: 2] == 2'd1) ns = 3;
        3: begin tag = "R7"; if (evt[t*2 +: 2] == 2'd3) ns = stl ? 2 : 5; end
        5: ns = 0;
        default: ns = st;
      endcase
    end
    return ns;
  endfunction

  task automatic step();
    logic any_live = 1'b0;
    for (int t = 0; t < NT; t++) begin
      logic [3:0] fs = sset[t*4 +: 4];
      logic [3:0] fc = sclr[t*4 +: 4];
      logic c, r, cn;
      string tag;
      e_fl[t]  = (m_fl[t] | fs) & ~fc;
      e_err[t] = |(fc & (~m_fl[t] | fs));
      e_st[t]  = rule_next(t, ctx || (|e_fl[t]), c, r, cn, tag);
      e_chg[t] = c; e_rv[t] = r; e_can[t] = cn; e_tag[t] = tag;
      if (r) m_pc[t] = csq[t] ? cpc[t*AW +: AW] : dpc[t*AW +: AW];
      if (thr_en[t] && (e_st[t] == 0 || e_st[t] == 1 || e_st[t] == 5)) any_live = 1'b1;
    end
    e_act = any_live; e_actp = any_live & ~m_act; e_deactp = ~any_live & m_act;
    @(posedge clk);
    @(negedge clk);
    for (int t = 0; t < NT; t++) begin
      chk(e_tag[t], $sformatf("status t%0d", t), status[t*3 +: 3], e_st[t]);
      chk(e_tag[t], $sformatf("status_chg t%0d", t), chg[t], e_chg[t]);
      chk(e_tag[t], $sformatf("redir_valid t%0d", t), rv[t], e_rv[t]);
      chk(e_tag[t], $sformatf("cancel t%0d", t), cancel[t], e_can[t]);
      if (e_rv[t]) chk(e_tag[t], $sformatf("redir_pc t%0d", t), rpc[t*AW +: AW], m_pc[t]);
      chk("R1", $sformatf("flags t%0d", t), flags[t*4 +: 4], e_fl[t]);
      chk("R2", $sformatf("flag_err t%0d", t), ferr[t], e_err[t]);
      m_st[t] = e_st[t]; m_fl[t] = e_fl[t];
    end
    chk("R10", "stage_active", act_lvl, e_act);
    chk("R10", "stage_act", act_p, e_actp);
    chk("R10", "stage_deact", deact_p, e_deactp);
    m_act = e_act;
  endtask

  task automatic idle_inputs();
    ctx = 0; sset = '0; sclr = '0; csq = '0; rob = '0; dsq = '0; evt = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 20240611;
    void'($urandom(seed));
    thr_en = '1; cpc = '0; dpc = '0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    for (int t = 0; t < NT; t++) begin
      chk("R11", "reset status", status[t*3 +: 3], 0);
      chk("R11", "reset flags", flags[t*4 +: 4], 0);
      m_st[t] = 0; m_fl[t] = '0; m_pc[t] = '0;
    end
    chk("R11", "reset active", act_lvl, 0);
    chk("R11", "reset act pulse", act_p, 0);
    m_act = 0;
    rst_n = 1'b1;
    step();  // R10 activation pulse after reset

    // directed: R9 issue, R6 stall during wait held (R7), response while stalled -> Blocked
    evt = 2'b01;               step(); idle_inputs();
    sset = 4'b0001;            step(); idle_inputs();
    evt = 2'b11;               step(); idle_inputs();
    sclr = 4'b0001;            step(); idle_inputs();   // R8 release
    // R3 commit squash cancels a pending wait
    evt = 2'b01;               step(); idle_inputs();
    csq = 2'b01; cpc[AW-1:0] = 16'hBEEF; dsq = 2'b01; dpc[AW-1:0] = 16'h1234;
    step(); idle_inputs();
    // R5 decode squash ignored while Squashing (status is 1 now)
    dsq = 2'b01; dpc[AW-1:0] = 16'h5555; step(); idle_inputs();
    // R2 unblock on clear flag, and block+unblock together
    sclr = 8'h10;              step(); idle_inputs();
    sset = 8'h02; sclr = 8'h02; step(); idle_inputs();
    // R4 rob busy, R10 deactivate by disabling threads
    rob = 2'b10;               step(); idle_inputs();
    thr_en = '0; ctx = 1;      step(); idle_inputs();
    thr_en = '1;               step();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      idle_inputs();
      for (int t = 0; t < NT; t++) begin
        for (int s = 0; s < 4; s++) begin
          if ($urandom_range(0, 7) == 0) sset[t*4+s] = 1'b1;
          if (m_fl[t][s] ? ($urandom_range(0, 5) == 0) : ($urandom_range(0, 63) == 0))
            sclr[t*4+s] = 1'b1;
        end
        csq[t] = ($urandom_range(0, 15) == 0);
        rob[t] = ($urandom_range(0, 15) == 0);
        dsq[t] = ($urandom_range(0, 7) == 0);
        cpc[t*AW +: AW] = AW'($urandom);
        dpc[t*AW +: AW] = AW'($urandom);
        evt[t*2 +: 2] = ($urandom_range(0, 1) == 0) ? 2'd0 : 2'($urandom_range(1, 3));
      end
      ctx = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 31) == 0) thr_en = NT'($urandom);
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule